// File: doc/BRIEF.md
# Per-Target Highest-Priority Interrupt Selector

This block keeps a table of shared peripheral interrupts. Each entry holds a priority, an enable bit, a pending bit, an active bit, a target affinity ID and a domain number. For every pair of a domain and a target CPU, the block holds a registered best pending interrupt (ID plus priority). Each time that register is rewritten, the block pulses a one-cycle change strobe to the CPU's interface. A register-style write port edits the fields of one entry at a time. One input wire per interrupt carries its raw level, and a rising edge on that wire sets the entry's pending bit.

Recomputation is a sequential scan over the table, one entry per clock. Requests for recomputation are kept as dirty bits, one for each domain/CPU slot, and are served in round-robin order. Each domain has a controller-enable bit. While that bit is clear, nothing is forwarded for the domain. Clearing the bit recalls every best register of the domain at once.

Top module: `hppi_selector`

## Requirements
- R1: An entry is a candidate only if it is pending, enabled and not active.
- R2: A lower priority value is more urgent. A candidate replaces the running best only when its priority is strictly lower, so on a tie the lower-indexed entry is kept.
- R3: After reset, every best register holds ID 0 with the idle priority (all ones, 31 by default), and no change strobe is raised. Any best register at idle priority shows ID 0.
- R4: The best register of slot `dom*NUM_CPU + cpu` considers only entries whose domain equals `dom` and whose target affinity ID equals `cpu`. The CPU with index n has affinity ID n.
- R5: A reported ID is `{type[1:0], index}`, where type is 2'b11 for these entries. Entry 5 therefore reports 7'h65 at the default size.
- R6: A write to the priority field (code 0), the enable field (code 1), the pending field (code 2) or the active field (code 3), or a rising edge on the entry's level input, recomputes the slot the entry targets.
- R7: Writing the target field (code 4) recomputes both the old and the new target slot. Writing the domain field (code 5) recomputes the entry's slot in both the old and the new domain.
- R8: While a domain's enable bit is clear, its best registers stay at ID 0 with idle priority and raise no strobe. Clearing the bit resets all of that domain's best registers and pulses the change strobe of each of them once. Setting the bit recomputes every slot of the domain.
- R9: A target affinity ID at or above NUM_CPU matches no CPU and causes no update and no change strobe.
- R10: The control readback for a domain is `{idle, enable}`. The idle bit (bit 1) always reads 1, and bit 0 shows the domain's enable bit.
- R11: `busy` is high for exactly NUM_IRQ cycles per scan. Every rewrite of a best register pulses that slot's change strobe for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Entry field write strobe |
| wrSel | input | IDX_W | Entry index to write |
| wrField | input | 3 | Field code (0 prio, 1 enable, 2 pending, 3 active, 4 target, 5 domain) |
| wrData | input | DATA_W | Write value (low bits used) |
| irqLevel | input | NUM_IRQ | Raw interrupt levels; a rising edge sets pending |
| ctrlWrEn | input | 1 | Domain enable write strobe |
| ctrlWrDom | input | DOM_W | Domain for the enable write |
| ctrlWrData | input | 1 | New enable value |
| ctrlRdDom | input | DOM_W | Domain selected for readback |
| ctrlRdData | output | 2 | {idle, enable} of the selected domain |
| bestId | output | NSLOT*ID_W | Best ID per slot, slot s at bits s*ID_W |
| bestPrio | output | NSLOT*PRIO_W | Best priority per slot |
| changed | output | NSLOT | One-cycle change strobe per slot |
| busy | output | 1 | High while a scan runs |

## Verification
The hardest cases are the ones where two rules meet: a recall of a domain while scans for that domain are queued or running, and a retarget that must refresh a slot the entry is leaving. The bench builds up a known table one field write at a time. It drives a domain disable after several slots have live winners, then writes entries while the domain is off, and checks that the change-strobe counts stay flat until the domain is enabled again. For unmatched affinity, the bench moves an entry to affinity 7 and counts strobes on every slot, so that only the old owner's refresh shows.

// File: rtl/hppi_pkg.sv
package hppi_pkg;

  typedef struct packed {
    logic scanInit;
    logic scanStep;
    logic commit;
    logic recall;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    FLD_PRIO   = 3'd0,
    FLD_ENABLE = 3'd1,
    FLD_PEND   = 3'd2,
    FLD_ACTIVE = 3'd3,
    FLD_TARGET = 3'd4,
    FLD_DOMAIN = 3'd5,
    FLD_RSVD6  = 3'd6,
    FLD_RSVD7  = 3'd7
  } wrField_e;

  localparam logic [1:0] TYPE_SHARED = 2'b11;

endpackage

// File: rtl/hppi_datapath.sv
module hppi_datapath
  import hppi_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_CPU = 4,
  parameter int NUM_DOM = 2,
  parameter int PRIO_W  = 5,
  parameter int AFF_W   = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int ID_W   = IDX_W + 2,
  localparam int NSLOT  = NUM_DOM * NUM_CPU,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrSel,
  input  logic [2:0]              wrField,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [NUM_IRQ-1:0]      irqLevel,
  input  ctlStrobe_t              strb,
  input  logic [SLOT_W-1:0]       scanSlot,
  input  logic [IDX_W-1:0]        scanIdx,
  input  logic [DOM_W-1:0]        recallDom,
  output logic [NSLOT-1:0]        reqMark,
  output logic [NSLOT*ID_W-1:0]   bestId,
  output logic [NSLOT*PRIO_W-1:0] bestPrio,
  output logic [NSLOT-1:0]        changed
);

  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;
  localparam logic [IDX_W:0]    IRQ_LIM   = (IDX_W+1)'(NUM_IRQ);
  localparam logic [AFF_W:0]    CPU_LIM   = (AFF_W+1)'(NUM_CPU);
  localparam logic [DOM_W:0]    DOM_LIM   = (DOM_W+1)'(NUM_DOM);

  // entry table
  logic [PRIO_W-1:0]  prioQ [NUM_IRQ];
  logic [AFF_W-1:0]   affQ  [NUM_IRQ];
  logic [DOM_W-1:0]   domQ  [NUM_IRQ];
  logic [NUM_IRQ-1:0] enQ, pendQ, actQ, levelQ;
  logic [NUM_IRQ-1:0] levelRise;
  logic               wrHit;
  wrField_e           fieldSel;

  assign levelRise = irqLevel & ~levelQ;
  assign wrHit     = wrEn && ({1'b0, wrSel} < IRQ_LIM);
  assign fieldSel  = wrField_e'(wrField);

  function automatic logic [NSLOT-1:0] slotBit(input logic [DOM_W-1:0] d,
                                               input logic [AFF_W-1:0] a);
    logic [NSLOT-1:0] m;
    m = '0;
    if (({1'b0, a} < CPU_LIM) && ({1'b0, d} < DOM_LIM))
      m[int'(d) * NUM_CPU + int'(a)] = 1'b1;
    return m;
  endfunction

  // recompute requests from level edges and field writes
  always_comb begin
    reqMark = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (levelRise[i]) reqMark = reqMark | slotBit(domQ[i], affQ[i]);
    if (wrHit) begin
      unique case (fieldSel)
        FLD_PRIO, FLD_ENABLE, FLD_PEND, FLD_ACTIVE:
          reqMark = reqMark | slotBit(domQ[wrSel], affQ[wrSel]);
        FLD_TARGET:
          reqMark = reqMark | slotBit(domQ[wrSel], affQ[wrSel])
                            | slotBit(domQ[wrSel], wrData[AFF_W-1:0]);
        FLD_DOMAIN:
          reqMark = reqMark | slotBit(domQ[wrSel], affQ[wrSel])
                            | slotBit(wrData[DOM_W-1:0], affQ[wrSel]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_IRQ; i++) begin
        prioQ[i] <= PRIO_IDLE;
        affQ[i]  <= '0;
        domQ[i]  <= '0;
      end
      enQ    <= '0;
      pendQ  <= '0;
      actQ   <= '0;
      levelQ <= '0;
    end else begin
      levelQ <= irqLevel;
      for (int i = 0; i < NUM_IRQ; i++)
        if (levelRise[i]) pendQ[i] <= 1'b1;
      if (wrHit) begin
        unique case (fieldSel)
          FLD_PRIO:   prioQ[wrSel] <= wrData[PRIO_W-1:0];
          FLD_ENABLE: enQ[wrSel]   <= wrData[0];
          FLD_PEND:   pendQ[wrSel] <= wrData[0];
          FLD_ACTIVE: actQ[wrSel]  <= wrData[0];
          FLD_TARGET: affQ[wrSel]  <= wrData[AFF_W-1:0];
          FLD_DOMAIN: domQ[wrSel]  <= wrData[DOM_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // scan evaluation
  logic [DOM_W-1:0]  slotDom;
  logic [AFF_W-1:0]  slotCpu;
  logic [PRIO_W-1:0] runPrio, nextPrio;
  logic [IDX_W-1:0]  runIdx, nextIdx;
  logic              runValid, nextValid, stepWin;

  assign slotDom = DOM_W'(int'(scanSlot) / NUM_CPU);
  assign slotCpu = AFF_W'(int'(scanSlot) % NUM_CPU);

  always_comb begin
    stepWin = pendQ[scanIdx] && enQ[scanIdx] && !actQ[scanIdx]
           && (domQ[scanIdx] == slotDom) && (affQ[scanIdx] == slotCpu)
           && (prioQ[scanIdx] < runPrio);
    nextPrio  = stepWin ? prioQ[scanIdx] : runPrio;
    nextIdx   = stepWin ? scanIdx : runIdx;
    nextValid = stepWin || runValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runPrio  <= PRIO_IDLE;
      runIdx   <= '0;
      runValid <= 1'b0;
    end else if (strb.scanInit) begin
      runPrio  <= PRIO_IDLE;
      runIdx   <= '0;
      runValid <= 1'b0;
    end else if (strb.scanStep) begin
      runPrio  <= nextPrio;
      runIdx   <= nextIdx;
      runValid <= nextValid;
    end
  end

  // best registers per slot
  logic [ID_W-1:0]   bestIdQ   [NSLOT];
  logic [PRIO_W-1:0] bestPrioQ [NSLOT];
  logic [NSLOT-1:0]  changedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSLOT; s++) begin
        bestIdQ[s]   <= '0;
        bestPrioQ[s] <= PRIO_IDLE;
      end
      changedQ <= '0;
    end else begin
      changedQ <= '0;
      if (strb.recall) begin
        for (int s = 0; s < NSLOT; s++) begin
          if ((s / NUM_CPU) == int'(recallDom)) begin
            bestIdQ[s]   <= '0;
            bestPrioQ[s] <= PRIO_IDLE;
            changedQ[s]  <= 1'b1;
          end
        end
      end
      if (strb.commit) begin
        bestIdQ[scanSlot]   <= nextValid ? {TYPE_SHARED, nextIdx} : '0;
        bestPrioQ[scanSlot] <= nextPrio;
        changedQ[scanSlot]  <= 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_flat
    assign bestId[s*ID_W +: ID_W]       = bestIdQ[s];
    assign bestPrio[s*PRIO_W +: PRIO_W] = bestPrioQ[s];
  end
  assign changed = changedQ;

endmodule

// File: rtl/hppi_control.sv
module hppi_control
  import hppi_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_CPU = 4,
  parameter int NUM_DOM = 2,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int NSLOT  = NUM_DOM * NUM_CPU,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSLOT-1:0]  reqMark,
  input  logic              ctrlWrEn,
  input  logic [DOM_W-1:0]  ctrlWrDom,
  input  logic              ctrlWrData,
  input  logic [DOM_W-1:0]  ctrlRdDom,
  output ctlStrobe_t        strb,
  output logic [SLOT_W-1:0] scanSlot,
  output logic [IDX_W-1:0]  scanIdx,
  output logic [DOM_W-1:0]  recallDom,
  output logic [1:0]        ctrlRdData,
  output logic [NUM_DOM-1:0] domEn,
  output logic              busy
);

  typedef enum logic {ST_IDLE, ST_SCAN} state_e;

  localparam logic [DOM_W:0]   DOM_LIM  = (DOM_W+1)'(NUM_DOM);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_IRQ - 1);

  state_e            stateQ;
  logic [NSLOT-1:0]  dirtyQ;
  logic [NUM_DOM-1:0] domEnQ;
  logic [SLOT_W-1:0] slotQ, ptrQ;
  logic [IDX_W-1:0]  idxQ;

  logic              ctrlHit;
  logic [NUM_DOM-1:0] effEn;
  logic [NSLOT-1:0]  enMask, enableMark, avail, clrMask;
  logic [SLOT_W:0]   pickRes;
  logic              lastIdx;

  function automatic logic [SLOT_W:0] rrPick(input logic [NSLOT-1:0] v,
                                             input logic [SLOT_W-1:0] p);
    logic [SLOT_W:0] r;
    r = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      int j;
      j = (int'(p) + k) % NSLOT;
      if (v[j]) r = {1'b1, SLOT_W'(j)};
    end
    return r;
  endfunction

  assign ctrlHit = ctrlWrEn && ({1'b0, ctrlWrDom} < DOM_LIM);

  always_comb begin
    for (int d = 0; d < NUM_DOM; d++)
      effEn[d] = (ctrlHit && int'(ctrlWrDom) == d) ? ctrlWrData : domEnQ[d];
    for (int s = 0; s < NSLOT; s++) begin
      enMask[s]     = effEn[s / NUM_CPU];
      enableMark[s] = ctrlHit && ctrlWrData && (int'(ctrlWrDom) == s / NUM_CPU);
    end
  end

  assign avail   = dirtyQ & enMask;
  assign pickRes = rrPick(avail, ptrQ);
  assign lastIdx = (idxQ == LAST_IDX);

  always_comb begin
    strb    = '0;
    clrMask = '0;
    unique case (stateQ)
      ST_IDLE: if (pickRes[SLOT_W]) begin
        strb.scanInit = 1'b1;
        clrMask[pickRes[SLOT_W-1:0]] = 1'b1;
      end
      ST_SCAN: begin
        strb.scanStep = 1'b1;
        strb.commit   = lastIdx && enMask[slotQ];
      end
      default: ;
    endcase
    strb.recall = ctrlHit && !ctrlWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      dirtyQ <= '0;
      domEnQ <= '0;
      slotQ  <= '0;
      ptrQ   <= '0;
      idxQ   <= '0;
    end else begin
      dirtyQ <= ((dirtyQ & ~clrMask) | reqMark | enableMark) & enMask;
      if (ctrlHit) domEnQ[ctrlWrDom] <= ctrlWrData;
      unique case (stateQ)
        ST_IDLE: if (pickRes[SLOT_W]) begin
          stateQ <= ST_SCAN;
          slotQ  <= pickRes[SLOT_W-1:0];
          idxQ   <= '0;
          ptrQ   <= (int'(pickRes[SLOT_W-1:0]) == NSLOT - 1) ? '0
                                                             : pickRes[SLOT_W-1:0] + 1'b1;
        end
        ST_SCAN: begin
          if (lastIdx) stateQ <= ST_IDLE;
          else         idxQ   <= idxQ + 1'b1;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign scanSlot   = slotQ;
  assign scanIdx    = idxQ;
  assign recallDom  = ctrlWrDom;
  assign domEn      = domEnQ;
  assign busy       = (stateQ == ST_SCAN);
  assign ctrlRdData = {1'b1, ({1'b0, ctrlRdDom} < DOM_LIM) ? domEnQ[ctrlRdDom] : 1'b0};

endmodule

// File: rtl/hppi_selector.sv
module hppi_selector
  import hppi_pkg::*;
#(
  parameter int NUM_IRQ = 32,
  parameter int NUM_CPU = 4,
  parameter int NUM_DOM = 2,
  parameter int PRIO_W  = 5,
  parameter int AFF_W   = 4,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ),
  localparam int ID_W   = IDX_W + 2,
  localparam int NSLOT  = NUM_DOM * NUM_CPU,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int DOM_W  = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrSel,
  input  logic [2:0]              wrField,
  input  logic [DATA_W-1:0]       wrData,
  input  logic [NUM_IRQ-1:0]      irqLevel,
  input  logic                    ctrlWrEn,
  input  logic [DOM_W-1:0]        ctrlWrDom,
  input  logic                    ctrlWrData,
  input  logic [DOM_W-1:0]        ctrlRdDom,
  output logic [1:0]              ctrlRdData,
  output logic [NSLOT*ID_W-1:0]   bestId,
  output logic [NSLOT*PRIO_W-1:0] bestPrio,
  output logic [NSLOT-1:0]        changed,
  output logic                    busy
);

  ctlStrobe_t        strb;
  logic [SLOT_W-1:0] scanSlot;
  logic [IDX_W-1:0]  scanIdx;
  logic [DOM_W-1:0]  recallDom;
  logic [NSLOT-1:0]  reqMark;
  logic [NUM_DOM-1:0] domEnQ;

  hppi_control #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .NUM_DOM(NUM_DOM)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .reqMark(reqMark),
    .ctrlWrEn(ctrlWrEn), .ctrlWrDom(ctrlWrDom), .ctrlWrData(ctrlWrData),
    .ctrlRdDom(ctrlRdDom), .strb(strb), .scanSlot(scanSlot), .scanIdx(scanIdx),
    .recallDom(recallDom), .ctrlRdData(ctrlRdData), .domEn(domEnQ), .busy(busy)
  );

  hppi_datapath #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .NUM_DOM(NUM_DOM),
    .PRIO_W(PRIO_W), .AFF_W(AFF_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrField(wrField),
    .wrData(wrData), .irqLevel(irqLevel), .strb(strb), .scanSlot(scanSlot),
    .scanIdx(scanIdx), .recallDom(recallDom), .reqMark(reqMark),
    .bestId(bestId), .bestPrio(bestPrio), .changed(changed)
  );

endmodule

// File: rtl/hppi_selector_chk.sv
module hppi_selector_chk #(
  parameter int NUM_CPU = 4,
  parameter int NUM_DOM = 2,
  parameter int PRIO_W  = 5,
  parameter int ID_W    = 7,
  localparam int NSLOT  = NUM_DOM * NUM_CPU
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_DOM-1:0]      domEn,
  input logic [NSLOT*ID_W-1:0]   bestId,
  input logic [NSLOT*PRIO_W-1:0] bestPrio,
  input logic [NSLOT-1:0]        changed
);

  localparam logic [PRIO_W-1:0] PRIO_IDLE = '1;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !domEn[s / NUM_CPU] |-> bestPrio[s*PRIO_W +: PRIO_W] == PRIO_IDLE); // R8

    AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(domEn[s / NUM_CPU]) |-> changed[s]); // R8

    AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      bestPrio[s*PRIO_W +: PRIO_W] == PRIO_IDLE |-> bestId[s*ID_W +: ID_W] == '0); // R3

    AST_SHARED_TYPE: assert property (@(posedge clk) disable iff (!rstN)
      bestPrio[s*PRIO_W +: PRIO_W] != PRIO_IDLE |-> bestId[s*ID_W + ID_W - 1 -: 2] == 2'b11); // R5

    AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(bestPrio[s*PRIO_W +: PRIO_W]) |-> changed[s]); // R11
  end

endmodule

bind hppi_selector hppi_selector_chk #(
  .NUM_CPU(NUM_CPU), .NUM_DOM(NUM_DOM), .PRIO_W(PRIO_W), .ID_W(ID_W)
) chk_i (
  .clk(clk), .rstN(rstN), .domEn(domEnQ), .bestId(bestId),
  .bestPrio(bestPrio), .changed(changed)
);

// File: tb/hppi_selector_tb_top.sv
`timescale 1ns/1ps
module hppi_selector_tb_top;

  localparam int NUM_IRQ = 32;
  localparam int NUM_CPU = 4;
  localparam int NUM_DOM = 2;
  localparam int PRIO_W  = 5;
  localparam int ID_W    = 7;
  localparam int NSLOT   = 8;
  localparam int NVEC    = 17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrSel = '0;
  logic [2:0] wrField = '0;
  logic [7:0] wrData = '0;
  logic [NUM_IRQ-1:0] irqLevel = '0;
  logic ctrlWrEn = 1'b0;
  logic [0:0] ctrlWrDom = '0;
  logic ctrlWrData = 1'b0;
  logic [0:0] ctrlRdDom = '0;
  logic [1:0] ctrlRdData;
  logic [NSLOT*ID_W-1:0] bestId;
  logic [NSLOT*PRIO_W-1:0] bestPrio;
  logic [NSLOT-1:0] changed;
  logic busy;

  always #2.5 clk = ~clk;

  hppi_selector dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrField(wrField),
    .wrData(wrData), .irqLevel(irqLevel), .ctrlWrEn(ctrlWrEn),
    .ctrlWrDom(ctrlWrDom), .ctrlWrData(ctrlWrData), .ctrlRdDom(ctrlRdDom),
    .ctrlRdData(ctrlRdData), .bestId(bestId), .bestPrio(bestPrio),
    .changed(changed), .busy(busy)
  );

  int nCmp = 0;
  int nBad = 0;
  int chgCnt [NSLOT];
  int snap [NSLOT];
  bit finished = 1'b0;

  // vector: req(4) sel(5) field(3) data(8) slot(3) expId(7) expPrio(5); field 7 = no write
  localparam bit [34:0] VEC [NVEC] = '{
    {4'd6, 5'd5, 3'd0, 8'd10, 3'd0, 7'h00, 5'd31},  // R6 prio alone, not a candidate
    {4'd1, 5'd5, 3'd1, 8'd1,  3'd0, 7'h00, 5'd31},  // R1 enabled but not pending
    {4'd5, 5'd5, 3'd2, 8'd1,  3'd0, 7'h65, 5'd10},  // R5 R1 becomes candidate
    {4'd2, 5'd9, 3'd0, 8'd10, 3'd0, 7'h65, 5'd10},
    {4'd2, 5'd9, 3'd1, 8'd1,  3'd0, 7'h65, 5'd10},
    {4'd2, 5'd9, 3'd2, 8'd1,  3'd0, 7'h65, 5'd10},  // R2 tie keeps lower index
    {4'd2, 5'd9, 3'd0, 8'd4,  3'd0, 7'h69, 5'd4},   // R2 strictly lower wins
    {4'd1, 5'd9, 3'd3, 8'd1,  3'd0, 7'h65, 5'd10},  // R1 active excluded
    {4'd1, 5'd9, 3'd3, 8'd0,  3'd0, 7'h69, 5'd4},
    {4'd7, 5'd9, 3'd4, 8'd2,  3'd0, 7'h65, 5'd10},  // R7 old target refreshed
    {4'd7, 5'd0, 3'd7, 8'd0,  3'd2, 7'h69, 5'd4},   // R7 new target
    {4'd7, 5'd5, 3'd5, 8'd1,  3'd0, 7'h00, 5'd31},  // R7 old domain refreshed
    {4'd7, 5'd0, 3'd7, 8'd0,  3'd4, 7'h65, 5'd10},  // R7 new domain
    {4'd6, 5'd5, 3'd1, 8'd0,  3'd4, 7'h00, 5'd31},  // R6 enable cleared
    {4'd6, 5'd5, 3'd1, 8'd1,  3'd4, 7'h65, 5'd10},
    {4'd6, 5'd5, 3'd2, 8'd0,  3'd4, 7'h00, 5'd31},  // R6 pending cleared
    {4'd4, 5'd0, 3'd7, 8'd0,  3'd1, 7'h00, 5'd31}   // R4 other cpu sees nothing
  };

  task automatic check(input string req, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int getId(input int s);
    return int'(bestId[s*ID_W +: ID_W]);
  endfunction

  function automatic int getPrio(input int s);
    return int'(bestPrio[s*PRIO_W +: PRIO_W]);
  endfunction

  task automatic doWrite(input int sel, input int fld, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 5'(sel); wrField = 3'(fld); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ctrlWrite(input int dom, input bit en);
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrDom = 1'(dom); ctrlWrData = en;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      if (busy) q = 0; else q++;
    end
  endtask

  task automatic takeSnap();
    for (int s = 0; s < NSLOT; s++) snap[s] = chgCnt[s];
  endtask

  function automatic int deltaTotal();
    int t = 0;
    for (int s = 0; s < NSLOT; s++) t += chgCnt[s] - snap[s];
    return t;
  endfunction

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial for (int s = 0; s < NSLOT; s++) chgCnt[s] = 0;

  always @(negedge clk)
    if (rstN)
      for (int s = 0; s < NSLOT; s++)
        if (changed[s]) chgCnt[s]++;

  initial begin
    repeat (150000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int cnt;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);

    // R3 reset state
    for (int s = 0; s < NSLOT; s++) begin
      check("R3 reset id", getId(s), 0);
      check("R3 reset prio", getPrio(s), 31);
    end
    check("R3 reset busy", int'(busy), 0);
    check("R3 reset changed", int'(changed), 0);
    ctrlRdDom = 1'b0;
    #0.1;
    check("R10 readback disabled", int'(ctrlRdData), 2);

    ctrlWrite(0, 1'b1);
    ctrlWrite(1, 1'b1);
    waitIdle();
    check("R10 readback enabled", int'(ctrlRdData), 3);

    for (int v = 0; v < NVEC; v++) begin
      bit [34:0] e;
      int req, sel, fld, data, slot, eId, ePrio;
      e = VEC[v];
      req = int'(e[34:31]); sel = int'(e[30:26]); fld = int'(e[25:23]);
      data = int'(e[22:15]); slot = int'(e[14:12]); eId = int'(e[11:5]); ePrio = int'(e[4:0]);
      if (fld != 7) doWrite(sel, fld, data);
      waitIdle();
      check($sformatf("R%0d vec%0d id", req, v), getId(slot), eId);
      check($sformatf("R%0d vec%0d prio", req, v), getPrio(slot), ePrio);
    end

    // R9 unmatched affinity: only the old owner refreshes
    takeSnap();
    doWrite(9, 4, 7);
    waitIdle();
    check("R7 old owner after move to aff 7", getId(2), 0);
    check("R9 strobes on move to aff 7", deltaTotal(), 1);
    takeSnap();
    doWrite(9, 0, 2);
    waitIdle();
    check("R9 no strobe for unmatched target", deltaTotal(), 0);

    // R6 level edge
    doWrite(3, 0, 1);
    doWrite(3, 1, 1);
    doWrite(3, 4, 1);
    waitIdle();
    check("R1 not pending before edge", getId(1), 0);
    @(negedge clk) irqLevel[3] = 1'b1;
    waitIdle();
    check("R6 level edge id", getId(1), 'h63);
    check("R6 level edge prio", getPrio(1), 1);

    // R8 disable recall
    takeSnap();
    ctrlWrite(0, 1'b0);
    waitIdle();
    check("R8 recall id", getId(1), 0);
    check("R8 recall prio", getPrio(1), 31);
    for (int s = 0; s < NSLOT; s++)
      check($sformatf("R8 recall strobe slot%0d", s), chgCnt[s] - snap[s], (s < 4) ? 1 : 0);
    check("R10 readback after disable", int'(ctrlRdData), 2);
    takeSnap();
    doWrite(3, 0, 0);
    waitIdle();
    check("R8 gated id", getId(1), 0);
    check("R8 gated strobes", deltaTotal(), 0);
    ctrlWrite(0, 1'b1);
    waitIdle();
    check("R8 re-enable id", getId(1), 'h63);
    check("R8 re-enable prio", getPrio(1), 0);

    // R11 scan length
    doWrite(3, 0, 0);
    @(negedge clk);
    check("R11 busy after request", int'(busy), 1);
    cnt = busy ? 1 : 0;
    while (busy) begin
      @(negedge clk);
      if (busy) cnt++;
    end
    check("R11 scan cycles", cnt, NUM_IRQ);
    waitIdle();

    finishRun();
  end

endmodule